// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block generates the timing for a parallel RGB TFT panel. It produces a pixel clock enable, active-low horizontal and vertical sync, a data-enable strobe, and the column and row of the pixel being shown. A host sets every interval through a small write-only register file. Each interval is stored as its length minus one.

The host programs the intervals while video is off and sets the enable bit last. Enabled, the block divides the system clock down to the pixel rate. It walks each line and then each frame through four phases in this order: sync, back porch, active, front porch. Each frame start raises a pending flag, and that flag drives the interrupt output unless it is masked. Pixel fetch and the colour path sit outside this block.

Top module: `lcd_timing_gen`

## Requirements
- R1: Writes take effect on the clock edge that samples `wr_en`. Register map, by `wr_addr`:
  - 0 = control: bit 0 is the enable, bits 25:16 are the divisor CV.
  - 1 = horizontal timing: bits 7:0 sync, 15:8 back porch, 23:16 front porch.
  - 2 = vertical timing: bits 7:0 sync, 15:8 back porch, 23:16 front porch.
  - 3 = size: bits 10:0 pixels per line, 25:16 active lines.
  - 4 = interrupt mask: bit 0, 1 means masked, reset value 1.
  - 5 = pending: write-one-to-clear at bit 0.
  - Every interval field holds its length minus one.
- R2: While enabled, `pix_ce` pulses for one cycle every 2*(CV+1) system cycles. The first pulse comes in the 2*(CV+1)-th cycle after enable rises.
- R3: Each line spends, in pixel periods, sync+1, then back porch+1, then active+1, then front porch+1. `hsync_n` is low only during the sync phase.
- R4: Each frame spends, in lines, sync+1, then back porch+1, then active+1, then front porch+1. `vsync_n` is low for the whole of each line in the vertical sync phase.
- R5: `de` is high only when both the horizontal and vertical phases are active. `pix_x` and `pix_y` count from 0 within the active region and read 0 elsewhere.
- R6: Clearing the enable bit forces both syncs high, `de` low and `pix_ce` low in the next cycle. Re-enabling starts a new frame at line 0, pixel 0, with a fresh divider count.
- R7: The pixel step that takes the frame from the last front-porch line back to sync sets the pending flag. `irq` is high whenever the flag is set and the mask is clear.
- R8: Writing a 1 to bit 0 of the pending register clears the flag. Writing 0 there leaves it unchanged. Disabling video also leaves it unchanged.
- R9: While the mask bit is 1, `irq` stays low but the flag is still set and kept. Clearing the mask then raises `irq`.
- R10: CV = 0 gives a pixel period of two system cycles.
- R11: After reset: `hsync_n`=1, `vsync_n`=1, `de`=0, `pix_ce`=0, `video_on`=0, `irq`=0.
- R12: While the enable bit is 0, writing timing registers produces no `pix_ce` pulse and no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Write data |
| pix_ce | output | 1 | Pixel clock enable, one system cycle wide |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active region |
| pix_x | output | 11 | Active column |
| pix_y | output | 10 | Active row |
| video_on | output | 1 | Current enable state |
| irq | output | 1 | Frame interrupt (pending and not masked) |

## Verification
Timing is counted from the edge that writes the enable bit; call the cycle after it cycle 0. From there `pix_ce` is due in cycle k when k mod 2*(CV+1) equals 2*CV+1. The sync, `de` and coordinate outputs for pixel floor(k/(2*(CV+1))) are due in cycle k, because they decode the counter registers directly. `irq` is due exactly one frame's worth of system cycles after cycle 0, one register stage after the last step. The bench recomputes all of these from the programmed field values for every cycle of a frame and more, sampling at the falling edge. A register write is checked on the first falling edge after the rising edge that takes it.

// File: rtl/lcd_timing_pkg.sv
// Shared definitions for the LCD timing generator: phase encoding and
// register indices. Assumes a 3-bit register index and 32-bit write data.
package lcd_timing_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_HTIM  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_VTIM  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_SIZE  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_IMASK = 3'd4;
    localparam logic [ADDR_W-1:0] REG_IPEND = 3'd5;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;
endpackage

// File: rtl/lcd_timing_regs.sv
// Host register file plus frame interrupt pending/mask logic.
// Assumes SYNC_W <= 8 so the porch/sync fields fit their byte lanes,
// HACT_W <= 16 and VACT_W + 16 <= 32, DIV_W + 16 <= 32.
module lcd_timing_regs
    import lcd_timing_pkg::*;
#(
    parameter int SYNC_W = 8,
    parameter int HACT_W = 11,
    parameter int VACT_W = 10,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_evt,
    output logic              cfg_en,
    output logic [DIV_W-1:0]  cfg_div,
    output logic [SYNC_W-1:0] h_sync,
    output logic [SYNC_W-1:0] h_back,
    output logic [SYNC_W-1:0] h_front,
    output logic [SYNC_W-1:0] v_sync,
    output logic [SYNC_W-1:0] v_back,
    output logic [SYNC_W-1:0] v_front,
    output logic [HACT_W-1:0] h_act,
    output logic [VACT_W-1:0] v_act,
    output logic              irq
);
    logic mask_q;
    logic pend_q;
    logic clr_wr;

    assign clr_wr = wr_en && (wr_addr == REG_IPEND) && wr_data[0];

    // Configuration registers, loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en  <= 1'b0;
            cfg_div <= '0;
            h_sync  <= '0;
            h_back  <= '0;
            h_front <= '0;
            v_sync  <= '0;
            v_back  <= '0;
            v_front <= '0;
            h_act   <= '0;
            v_act   <= '0;
            mask_q  <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    cfg_en  <= wr_data[0];
                    cfg_div <= wr_data[16 +: DIV_W];
                end
                REG_HTIM: begin
                    h_sync  <= wr_data[0 +: SYNC_W];
                    h_back  <= wr_data[8 +: SYNC_W];
                    h_front <= wr_data[16 +: SYNC_W];
                end
                REG_VTIM: begin
                    v_sync  <= wr_data[0 +: SYNC_W];
                    v_back  <= wr_data[8 +: SYNC_W];
                    v_front <= wr_data[16 +: SYNC_W];
                end
                REG_SIZE: begin
                    h_act <= wr_data[0 +: HACT_W];
                    v_act <= wr_data[16 +: VACT_W];
                end
                REG_IMASK: mask_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Pending flag: set by the frame event (priority), cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (frame_evt)
            pend_q <= 1'b1;
        else if (clr_wr)
            pend_q <= 1'b0;
    end

    assign irq = pend_q && !mask_q;

    a_r7_evt_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> pend_q);
    a_r8_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !frame_evt) |=> !pend_q);
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_wr) |=> pend_q);
    a_r9_masked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && frame_evt) |=> (pend_q && !irq));
endmodule

// File: rtl/lcd_pix_div.sv
// Pixel clock enable divider: one pulse every 2*(div+1) system cycles.
// Held at count zero while run is low, so each enable starts a fresh period.
module lcd_pix_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             pix_ce
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top;

    assign top    = {div, 1'b1};
    assign pix_ce = run && (cnt_q == top);

    // Period counter, wraps after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == top)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    a_r10_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);
    a_r6_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/lcd_axis_ctr.sv
// One timing axis: walks sync, back porch, active, front porch, each phase
// lasting its limit+1 steps. Assumes limits are stable while running.
module lcd_axis_ctr
    import lcd_timing_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] lim_sync,
    input  logic [CNT_W-1:0] lim_back,
    input  logic [CNT_W-1:0] lim_act,
    input  logic [CNT_W-1:0] lim_front,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cur_lim;
    logic             at_lim;
    phase_e           nxt_phase;

    // Select the limit of the current phase and the phase that follows it.
    always_comb begin
        case (phase)
            PH_SYNC:   begin cur_lim = lim_sync;  nxt_phase = PH_BACK;   end
            PH_BACK:   begin cur_lim = lim_back;  nxt_phase = PH_ACTIVE; end
            PH_ACTIVE: begin cur_lim = lim_act;   nxt_phase = PH_FRONT;  end
            default:   begin cur_lim = lim_front; nxt_phase = PH_SYNC;   end
        endcase
    end

    assign at_lim = (cnt == cur_lim);
    assign wrap   = step && (phase == PH_FRONT) && at_lim;

    // Phase and in-phase position, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (at_lim) begin
                phase <= nxt_phase;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !at_lim) |=> (cnt == $past(cnt) + 1'b1));
    a_r4_wrap_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> (phase == PH_SYNC && cnt == '0));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> ($stable(cnt) && $stable(phase)));
endmodule

// File: rtl/lcd_timing_gen.sv
// LCD panel timing generator top: register file, pixel divider and the
// horizontal and vertical axis counters. Outputs decode counter state
// directly; all timing is inactive while the enable bit is clear.
module lcd_timing_gen
    import lcd_timing_pkg::*;
#(
    parameter int SYNC_W = 8,
    parameter int HACT_W = 11,
    parameter int VACT_W = 10,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              pix_ce,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [HACT_W-1:0] pix_x,
    output logic [VACT_W-1:0] pix_y,
    output logic              video_on,
    output logic              irq
);
    localparam int H_CNT_W = (HACT_W > SYNC_W) ? HACT_W : SYNC_W;
    localparam int V_CNT_W = (VACT_W > SYNC_W) ? VACT_W : SYNC_W;

    logic [DIV_W-1:0]   cfg_div;
    logic [SYNC_W-1:0]  h_sync, h_back, h_front;
    logic [SYNC_W-1:0]  v_sync, v_back, v_front;
    logic [HACT_W-1:0]  h_act;
    logic [VACT_W-1:0]  v_act;
    phase_e             h_phase, v_phase;
    logic [H_CNT_W-1:0] h_cnt;
    logic [V_CNT_W-1:0] v_cnt;
    logic               h_wrap, v_wrap;

    lcd_timing_regs #(
        .SYNC_W(SYNC_W), .HACT_W(HACT_W), .VACT_W(VACT_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_evt(v_wrap),
        .cfg_en(video_on), .cfg_div(cfg_div),
        .h_sync(h_sync), .h_back(h_back), .h_front(h_front),
        .v_sync(v_sync), .v_back(v_back), .v_front(v_front),
        .h_act(h_act), .v_act(v_act),
        .irq(irq)
    );

    lcd_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(video_on), .div(cfg_div), .pix_ce(pix_ce)
    );

    lcd_axis_ctr #(.CNT_W(H_CNT_W)) u_hctr (
        .clk(clk), .rst_n(rst_n), .clr(!video_on), .step(pix_ce),
        .lim_sync(H_CNT_W'(h_sync)), .lim_back(H_CNT_W'(h_back)),
        .lim_act(H_CNT_W'(h_act)), .lim_front(H_CNT_W'(h_front)),
        .phase(h_phase), .cnt(h_cnt), .wrap(h_wrap)
    );

    lcd_axis_ctr #(.CNT_W(V_CNT_W)) u_vctr (
        .clk(clk), .rst_n(rst_n), .clr(!video_on), .step(h_wrap),
        .lim_sync(V_CNT_W'(v_sync)), .lim_back(V_CNT_W'(v_back)),
        .lim_act(V_CNT_W'(v_act)), .lim_front(V_CNT_W'(v_front)),
        .phase(v_phase), .cnt(v_cnt), .wrap(v_wrap)
    );

    // Panel outputs decoded from the two axis states, gated by the enable.
    always_comb begin
        hsync_n = !(video_on && h_phase == PH_SYNC);
        vsync_n = !(video_on && v_phase == PH_SYNC);
        de      = video_on && h_phase == PH_ACTIVE && v_phase == PH_ACTIVE;
        pix_x   = de ? h_cnt[HACT_W-1:0] : '0;
        pix_y   = de ? v_cnt[VACT_W-1:0] : '0;
    end

    a_r5_de_syncs_off: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));
    a_r5_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pix_x <= h_act && pix_y <= v_act));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !video_on |-> (hsync_n && vsync_n && !de && !pix_ce));
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        pix_ce, hsync_n, vsync_n, de, video_on, irq;
    logic [10:0] pix_x;
    logic [9:0]  pix_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Programmed timing, in real counts
    localparam int HS = 2, HB = 2, HA = 4, HF = 1;
    localparam int VS = 1, VB = 2, VA = 2, VF = 1;

    always #4 clk = ~clk;

    lcd_timing_gen u_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_ce(pix_ce), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .video_on(video_on), .irq(irq)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Runs from the cycle after enable and compares every output each cycle.
    task automatic scan(int c, bit masked, int extra, string req);
        int per = 2 * (c + 1);
        int hl  = HS + HB + HA + HF;
        int vl  = VS + VB + VA + VF;
        int frm = hl * vl * per;
        int bad[7];
        int fa[7];
        int fe[7];
        for (int i = 0; i < 7; i++) bad[i] = 0;
        for (int k = 0; k < frm + extra; k++) begin
            int p  = k / per;
            int px = p % hl;
            int ln = (p / hl) % vl;
            bit hact = (px >= HS + HB) && (px < HS + HB + HA);
            bit vact = (ln >= VS + VB) && (ln < VS + VB + VA);
            int ex[7];
            int ac[7];
            ex[0] = ((k % per) == per - 1);  ac[0] = pix_ce;
            ex[1] = !(px < HS);              ac[1] = hsync_n;
            ex[2] = !(ln < VS);              ac[2] = vsync_n;
            ex[3] = hact && vact;            ac[3] = de;
            ex[4] = (hact && vact) ? px - HS - HB : 0; ac[4] = pix_x;
            ex[5] = (hact && vact) ? ln - VS - VB : 0; ac[5] = pix_y;
            ex[6] = (!masked && k >= frm);   ac[6] = irq;
            for (int i = 0; i < 7; i++)
                if (ac[i] != ex[i] && bad[i] == 0) begin
                    bad[i] = k + 1; fa[i] = ac[i]; fe[i] = ex[i];
                end
            @(posedge clk);
            @(negedge clk);
        end
        check(bad[0] == 0, {req, " R2"}, "pix_ce cadence", fa[0], fe[0]);
        check(bad[1] == 0, {req, " R3"}, "hsync_n per pixel", fa[1], fe[1]);
        check(bad[2] == 0, {req, " R4"}, "vsync_n per line", fa[2], fe[2]);
        check(bad[3] == 0, {req, " R5"}, "de", fa[3], fe[3]);
        check(bad[4] == 0 && bad[5] == 0, {req, " R5"}, "pix_x/pix_y",
              bad[4] != 0 ? fa[4] : fa[5], bad[4] != 0 ? fe[4] : fe[5]);
        check(bad[6] == 0, {req, masked ? " R9" : " R7"}, "irq timing", fa[6], fe[6]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hsync_n && vsync_n && !de && !pix_ce && !video_on && !irq,
              "R11", "idle outputs in reset",
              {hsync_n, vsync_n, de, pix_ce, video_on, irq}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        check(hsync_n && vsync_n && !de && !pix_ce && !video_on && !irq,
              "R11", "idle outputs after reset",
              {hsync_n, vsync_n, de, pix_ce, video_on, irq}, 6'b110000);
    endtask

    task automatic t_program_idle();
        int seen = 0;
        wr(3'd1, 32'((HF - 1) << 16 | (HB - 1) << 8 | (HS - 1)));
        wr(3'd2, 32'((VF - 1) << 16 | (VB - 1) << 8 | (VS - 1)));
        wr(3'd3, 32'((VA - 1) << 16 | (HA - 1)));
        wr(3'd4, 32'd0);
        for (int k = 0; k < 20; k++) begin
            if (pix_ce || !hsync_n || !vsync_n || de) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R12", "activity while disabled", seen, 0);
    endtask

    task automatic t_first_frame();
        wr(3'd0, 32'((1 << 16) | 1));
        check(video_on == 1'b1, "R1", "enable visible next cycle", video_on, 1);
        scan(1, 1'b0, 40, "R1");
    endtask

    task automatic t_disable_restart();
        int seen = 0;
        wr(3'd0, 32'(1 << 16));
        for (int k = 0; k < 10; k++) begin
            if (pix_ce || !hsync_n || !vsync_n || de || video_on) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R6", "outputs idle after disable", seen, 0);
        check(irq == 1'b1, "R8", "pending kept over disable", irq, 1);
        wr(3'd5, 32'd0);
        check(irq == 1'b1, "R8", "write 0 leaves pending", irq, 1);
        wr(3'd5, 32'd1);
        check(irq == 1'b0, "R8", "write 1 clears pending", irq, 0);
        wr(3'd0, 32'((2 << 16) | 1));
        scan(2, 1'b0, 12, "R6");
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd1);
    endtask

    task automatic t_mask();
        wr(3'd4, 32'd1);
        wr(3'd0, 32'd1);
        scan(0, 1'b1, 6, "R9");
        wr(3'd0, 32'd0);
        check(irq == 1'b0, "R9", "masked irq low", irq, 0);
        wr(3'd4, 32'd0);
        check(irq == 1'b1, "R9", "pending seen after unmask", irq, 1);
        wr(3'd5, 32'd1);
    endtask

    task automatic t_fastest();
        wr(3'd0, 32'd1);
        scan(0, 1'b0, 8, "R10");
        wr(3'd0, 32'd0);
    endtask

    initial begin
        t_reset();
        t_program_idle();
        t_first_frame();
        t_disable_restart();
        t_mask();
        t_fastest();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule